// File: doc/BRIEF.md
# Vectored Interrupt Controller with Non-Maskable Source

This block sits beside a simple processor core and decides which interrupt, if any, the core should service next. Each maskable peripheral source raises a one-cycle request that is latched into a pending flag. A flag reaches the core only when the source's own enable and a global enable bit are both set. When several maskable flags qualify, the lowest numbered one wins. A separate non-maskable source ignores every enable and outranks all the others.

The controller presents a request line, the number of the chosen interrupt and a handler address. The address is a table entry found by scaling the number by a fixed entry size and adding a table base supplied from outside. When the core accepts an interrupt, the chosen pending flag is cleared and the global enable is dropped, so a running handler is not preempted by maskable work. A return strobe from the core sets the global enable again. Software can also set or clear the global enable through single-cycle strobes, and it reads the bit back in the top bit of an 8-bit status byte.

Top module: `irq_vector_unit`

## Requirements
- R1: After reset no flag is pending, the global enable is 0, the status byte is 8'h00 and the request line is low.
- R2: A request pulse on a source sets its pending flag. A flag that is set but masked stays pending, and it is presented as soon as both its source enable and the global enable are 1.
- R3: A maskable source is presented only while its enable bit and the global enable are both 1.
- R4: Among presented maskable sources, the lowest source index wins.
- R5: The non-maskable source is interrupt number 0. It is presented whatever the enables are, and it outranks every maskable source.
- R6: Maskable source i is interrupt number i+1. The handler address equals the table base plus the number times 4, truncated to the address width.
- R7: An accept while the request line is high clears the pending flag of the presented interrupt and clears the global enable. An accept while the request line is low changes nothing.
- R8: A return strobe sets the global enable.
- R9: When updates to the global enable coincide, the priority is: accept clears, then return sets, then the clear strobe clears, then the set strobe sets.
- R10: Status bit 7 carries the global enable and bits 6 to 0 read as 0.
- R11: A new request pulse that arrives in the same cycle as the accept of that same source leaves the source pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcReq | input | NUM_SRC | One-cycle request pulses, one per maskable source |
| nmiReq | input | 1 | One-cycle request pulse of the non-maskable source |
| srcEn | input | NUM_SRC | Per-source enable bits |
| gieSet | input | 1 | Strobe that sets the global enable |
| gieClr | input | 1 | Strobe that clears the global enable |
| vecBase | input | ADDR_W | Base address of the handler table |
| intAck | input | 1 | Core accepts the presented interrupt |
| retStrobe | input | 1 | Core returns from a handler |
| irq | output | 1 | Interrupt request to the core |
| irqNum | output | NUM_W | Number of the presented interrupt |
| vecAddr | output | ADDR_W | Handler address of the presented interrupt |
| status | output | 8 | Status byte; bit 7 is the global enable |

## Verification
The hardest situations to reach are coincidences: a fresh pulse in the same cycle as the accept that clears that source's flag, and an accept that lands together with a return strobe or with the set and clear strobes. The stimulus builds these on purpose. It first parks flags behind a cleared global enable or a cleared source enable. It then issues the accept in the same cycle as the colliding pulse or strobe, and after that releases the enables. Whether the flag survived can then be seen on the request and number outputs.

// File: rtl/irq_vector_pkg.sv
package irq_vector_pkg;
  // strobes from the sequencing control to the datapath
  typedef struct packed {
    logic take;  // presented interrupt accepted this cycle
    logic gie;   // current global enable
  } ctl_strobe_t;
endpackage

// File: rtl/irq_vector_seq.sv
module irq_vector_seq
  import irq_vector_pkg::*;
#(
  parameter int STATUS_W = 8,
  parameter int GIE_BIT  = 7
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                irq,
  input  logic                intAck,
  input  logic                retStrobe,
  input  logic                gieSet,
  input  logic                gieClr,
  output ctl_strobe_t         ctl,
  output logic [STATUS_W-1:0] status
);
  logic gieQ;
  logic takeNow;

  assign takeNow = intAck & irq;

  // entry > return > clear > set
  always_ff @(posedge clk) begin
    if (!rstN)          gieQ <= 1'b0;
    else if (takeNow)   gieQ <= 1'b0;
    else if (retStrobe) gieQ <= 1'b1;
    else if (gieClr)    gieQ <= 1'b0;
    else if (gieSet)    gieQ <= 1'b1;
  end

  always_comb begin
    ctl.take = takeNow;
    ctl.gie  = gieQ;
    status   = '0;
    status[GIE_BIT] = gieQ;
  end
endmodule

// File: rtl/irq_vector_path.sv
module irq_vector_path
  import irq_vector_pkg::*;
#(
  parameter int NUM_SRC     = 8,
  parameter int NUM_W       = 4,
  parameter int ADDR_W      = 16,
  parameter int ENTRY_BYTES = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcReq,
  input  logic               nmiReq,
  input  logic [NUM_SRC-1:0] srcEn,
  input  logic [ADDR_W-1:0]  vecBase,
  input  ctl_strobe_t        ctl,
  output logic               irq,
  output logic [NUM_W-1:0]   irqNum,
  output logic [ADDR_W-1:0]  vecAddr
);
  localparam int ENTRY_SHIFT = $clog2(ENTRY_BYTES);

  logic [NUM_SRC-1:0] pendQ;
  logic               nmiPendQ;
  logic [NUM_SRC-1:0] eligible;
  logic [NUM_SRC-1:0] selMask;
  logic [NUM_W-1:0]   pickIdx;

  assign eligible = pendQ & srcEn & {NUM_SRC{ctl.gie}};

  // lowest index wins: descending scan, last hit overwrites
  always_comb begin
    pickIdx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (eligible[i]) pickIdx = NUM_W'(i);
    end
  end

  always_comb begin
    selMask = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (!nmiPendQ && (|eligible) && (pickIdx == NUM_W'(i))) selMask[i] = 1'b1;
    end
  end

  // one pending flag per source; a new pulse beats the clear
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_pend
    always_ff @(posedge clk) begin
      if (!rstN) pendQ[g] <= 1'b0;
      else       pendQ[g] <= (pendQ[g] & ~(ctl.take & selMask[g])) | srcReq[g];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) nmiPendQ <= 1'b0;
    else       nmiPendQ <= (nmiPendQ & ~ctl.take) | nmiReq;
  end

  always_comb begin
    irq     = nmiPendQ | (|eligible);
    irqNum  = nmiPendQ ? '0 : pickIdx + NUM_W'(1);
    vecAddr = vecBase + (ADDR_W'(irqNum) << ENTRY_SHIFT);
  end
endmodule

// File: rtl/irq_vector_unit.sv
module irq_vector_unit
  import irq_vector_pkg::*;
#(
  parameter int NUM_SRC     = 8,
  parameter int ADDR_W      = 16,
  parameter int ENTRY_BYTES = 4,
  parameter int NUM_W       = $clog2(NUM_SRC + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcReq,
  input  logic               nmiReq,
  input  logic [NUM_SRC-1:0] srcEn,
  input  logic               gieSet,
  input  logic               gieClr,
  input  logic [ADDR_W-1:0]  vecBase,
  input  logic               intAck,
  input  logic               retStrobe,
  output logic               irq,
  output logic [NUM_W-1:0]   irqNum,
  output logic [ADDR_W-1:0]  vecAddr,
  output logic [7:0]         status
);
  ctl_strobe_t ctl;

  irq_vector_seq #(.STATUS_W(8), .GIE_BIT(7)) u_seq (
    .clk(clk), .rstN(rstN), .irq(irq), .intAck(intAck),
    .retStrobe(retStrobe), .gieSet(gieSet), .gieClr(gieClr),
    .ctl(ctl), .status(status)
  );

  irq_vector_path #(
    .NUM_SRC(NUM_SRC), .NUM_W(NUM_W), .ADDR_W(ADDR_W), .ENTRY_BYTES(ENTRY_BYTES)
  ) u_path (
    .clk(clk), .rstN(rstN), .srcReq(srcReq), .nmiReq(nmiReq),
    .srcEn(srcEn), .vecBase(vecBase), .ctl(ctl),
    .irq(irq), .irqNum(irqNum), .vecAddr(vecAddr)
  );
endmodule

// File: rtl/irq_vector_chk.sv
module irq_vector_chk #(
  parameter int NUM_SRC     = 8,
  parameter int ADDR_W      = 16,
  parameter int ENTRY_BYTES = 4,
  parameter int NUM_W       = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SRC-1:0] srcEn,
  input logic               nmiReq,
  input logic               gieSet,
  input logic               gieClr,
  input logic [ADDR_W-1:0]  vecBase,
  input logic               intAck,
  input logic               retStrobe,
  input logic               irq,
  input logic [NUM_W-1:0]   irqNum,
  input logic [ADDR_W-1:0]  vecAddr,
  input logic [7:0]         status
);
  logic selEn;
  always_comb begin
    selEn = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (int'(irqNum) == i + 1) selEn = srcEn[i];
    end
  end

  p_idle_after_reset_r1: assert property (@(posedge clk)
    $rose(rstN) |-> (!irq && status == 8'h00));

  p_masked_needs_enables_r3: assert property (@(posedge clk) disable iff (!rstN)
    (irq && irqNum != '0) |-> (status[7] && selEn));

  p_nmi_presented_r5: assert property (@(posedge clk) disable iff (!rstN)
    nmiReq |=> (irq && irqNum == '0));

  p_vector_scaled_r6: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (vecAddr == ADDR_W'(vecBase + ADDR_W'(irqNum) * ADDR_W'(ENTRY_BYTES))));

  p_entry_clears_gie_r7: assert property (@(posedge clk) disable iff (!rstN)
    (intAck && irq) |=> !status[7]);

  p_return_sets_gie_r8: assert property (@(posedge clk) disable iff (!rstN)
    (retStrobe && !(intAck && irq)) |=> status[7]);

  p_clear_beats_set_r9: assert property (@(posedge clk) disable iff (!rstN)
    (gieClr && !retStrobe) |=> !status[7]);

  p_status_low_bits_r10: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (status[6:0] == 7'd0 && $past(rstN)));
endmodule

bind irq_vector_unit irq_vector_chk #(
  .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .ENTRY_BYTES(ENTRY_BYTES), .NUM_W(NUM_W)
) u_chk (
  .clk(clk), .rstN(rstN), .srcEn(srcEn), .nmiReq(nmiReq), .gieSet(gieSet),
  .gieClr(gieClr), .vecBase(vecBase), .intAck(intAck), .retStrobe(retStrobe),
  .irq(irq), .irqNum(irqNum), .vecAddr(vecAddr), .status(status)
);

// File: tb/irq_vector_unit_bench.sv
`timescale 1ns/1ps
module irq_vector_unit_bench;
  localparam int NUM_SRC = 8;
  localparam int ADDR_W  = 16;
  localparam int NUM_W   = 4;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic [NUM_SRC-1:0] srcReq = '0;
  logic               nmiReq = 1'b0;
  logic [NUM_SRC-1:0] srcEn = '0;
  logic               gieSet = 1'b0;
  logic               gieClr = 1'b0;
  logic [ADDR_W-1:0]  vecBase = 16'h0400;
  logic               intAck = 1'b0;
  logic               retStrobe = 1'b0;
  logic               irq;
  logic [NUM_W-1:0]   irqNum;
  logic [ADDR_W-1:0]  vecAddr;
  logic [7:0]         status;

  always #2 clk = ~clk;

  irq_vector_unit #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .ENTRY_BYTES(4)) u_irq_vector_unit (
    .clk(clk), .rstN(rstN), .srcReq(srcReq), .nmiReq(nmiReq), .srcEn(srcEn),
    .gieSet(gieSet), .gieClr(gieClr), .vecBase(vecBase), .intAck(intAck),
    .retStrobe(retStrobe), .irq(irq), .irqNum(irqNum), .vecAddr(vecAddr),
    .status(status)
  );

  typedef struct {
    logic              irq;
    logic [NUM_W-1:0]  num;
    logic [ADDR_W-1:0] vec;
    logic [7:0]        stat;
    string             tag;
  } exp_t;

  exp_t expQ[$];
  int   testsRun = 0;
  int   testsFailed = 0;
  bit   finished = 1'b0;

  // driver: set one cycle of inputs at a falling edge, queue the outcome
  // expected after the next rising edge
  task automatic step(input logic [NUM_SRC-1:0] src, input logic nmi,
                      input logic [NUM_SRC-1:0] en, input logic gset,
                      input logic gclr, input logic ack, input logic ret,
                      input logic eIrq, input int eNum, input logic eGie,
                      input string tag);
    exp_t e;
    @(negedge clk);
    srcReq = src; nmiReq = nmi; srcEn = en; gieSet = gset;
    gieClr = gclr; intAck = ack; retStrobe = ret;
    e.irq  = eIrq;
    e.num  = NUM_W'(eNum);
    e.vec  = ADDR_W'(vecBase + ADDR_W'(eNum * 4));
    e.stat = {eGie, 7'b0};
    e.tag  = tag;
    expQ.push_back(e);
  endtask

  // monitor: sample 1 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      if (expQ.size() > 0) begin
        exp_t e;
        bit bad;
        #1;
        e = expQ.pop_front();
        testsRun++;
        bad = (irq !== e.irq) || (status !== e.stat) ||
              (e.irq && ((irqNum !== e.num) || (vecAddr !== e.vec)));
        if (bad) begin
          testsFailed++;
          $display("FAIL %s: irq=%0b num=%0d vec=%h status=%h expected irq=%0b num=%0d vec=%h status=%h",
                   e.tag, irq, irqNum, vecAddr, status, e.irq, e.num, e.vec, e.stat);
        end
      end
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    //    src       nmi  en        set clr ack ret  irq num gie
    step(8'h00, 0, 8'h00, 0, 0, 0, 0,  0, 0, 0, "R1 R10 reset state");
    step(8'h04, 0, 8'hFF, 0, 0, 0, 0,  0, 0, 0, "R2 R3 pending held while global enable off");
    step(8'h00, 0, 8'hFF, 1, 0, 0, 0,  1, 3, 1, "R9 R2 set strobe releases parked flag");
    step(8'h20, 0, 8'hFF, 0, 0, 0, 0,  1, 3, 1, "R4 lowest index wins");
    step(8'h00, 0, 8'hFB, 0, 0, 0, 0,  1, 6, 1, "R3 source enable masks index 2");
    step(8'h00, 0, 8'hFB, 0, 0, 1, 0,  0, 0, 0, "R7 accept clears flag and global enable");
    step(8'h00, 0, 8'hFB, 0, 0, 1, 0,  0, 0, 0, "R7 accept with request low ignored");
    step(8'h00, 0, 8'hFF, 1, 0, 0, 0,  1, 3, 1, "R2 masked flag survived");
    step(8'h00, 0, 8'hFF, 0, 1, 0, 0,  0, 0, 0, "R9 clear strobe");
    step(8'h00, 0, 8'hFF, 1, 1, 0, 0,  0, 0, 0, "R9 clear beats set");
    step(8'h00, 0, 8'hFF, 0, 0, 0, 1,  1, 3, 1, "R8 return sets global enable");
    step(8'h00, 1, 8'hFF, 0, 0, 0, 0,  1, 0, 1, "R5 non-maskable outranks");
    step(8'h00, 0, 8'hFF, 0, 0, 1, 0,  0, 0, 0, "R7 accept of non-maskable");
    step(8'h00, 1, 8'h00, 0, 0, 0, 0,  1, 0, 0, "R5 non-maskable bypasses enables");
    step(8'h00, 1, 8'h00, 0, 0, 1, 0,  1, 0, 0, "R11 pulse during accept stays pending");
    step(8'h00, 0, 8'h00, 0, 0, 1, 0,  0, 0, 0, "R7 non-maskable cleared");
    step(8'h00, 0, 8'hFF, 0, 0, 0, 1,  1, 3, 1, "R8 return releases index 2");
    step(8'h00, 0, 8'hFF, 0, 0, 1, 1,  0, 0, 0, "R9 accept beats return");
    step(8'h81, 0, 8'hFF, 1, 0, 0, 0,  1, 1, 1, "R4 R6 index 0 is number 1");
    step(8'h01, 0, 8'hFF, 0, 0, 1, 0,  0, 0, 0, "R11 same-source pulse during accept");
    step(8'h00, 0, 8'hFF, 1, 0, 0, 0,  1, 1, 1, "R11 flag re-armed by colliding pulse");
    step(8'h00, 0, 8'hFF, 0, 0, 1, 0,  0, 0, 0, "R7 accept index 0");
    vecBase = 16'hFFF0;
    step(8'h00, 0, 8'hFF, 0, 0, 0, 1,  1, 8, 1, "R6 address wraps at width");
    step(8'h00, 0, 8'hFF, 0, 0, 0, 0,  1, 8, 1, "R3 R10 held state");
    @(negedge clk);
    srcReq = '0; nmiReq = 0; gieSet = 0; gieClr = 0; intAck = 0; retStrobe = 0;
    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule